// File: doc/BRIEF.md
# Legacy UART Register File

This block is the host-facing register set of a byte-oriented serial port that follows the classic 16450 programming model. A processor reaches eight byte-wide registers through a simple synchronous bus (address, read strobe, write strobe, write data, combinational read data). The line side exchanges whole bytes only. It sends a byte with a one-cycle strobe and takes a done pulse back. It receives a byte through a valid strobe, or a break event through a separate input. One level interrupt output reports pending work.

The transmit side is a small state machine with three states. TX_EMPTY means the holding register is free. TX_WAIT_LINE means a byte was handed to the line and the block waits for done. TX_LOOPBACK means a byte was routed to the receive path and completes one cycle later. The transitions are:
- TX_EMPTY to TX_WAIT_LINE on a data write outside loopback.
- TX_EMPTY to TX_LOOPBACK on a data write in loopback.
- TX_WAIT_LINE to TX_EMPTY on done.
- TX_LOOPBACK to TX_EMPTY unconditionally.

A hidden transmit-interrupt pending flag works alongside this machine. It lets software acknowledge the transmit interrupt by reading the identification register. The divisor, character length and break level are exported as outputs for the bit-level serializer, which is not part of this block.

Top module: `uart_regfile`

## Requirements
- R1: After reset, IIR (addr 2) reads 0x01, LSR (addr 5) reads 0x60, MSR (addr 6) reads 0xB0, addresses 0,1,3,4,7 read 0x00, and irq is low.
- R2: While LCR bit 7 is set, address 0 and address 1 read and write the low and high byte of the 16-bit divisor, which drives the divisor output. With LCR bit 7 clear, address 1 accesses the interrupt-enable register, whose low 4 bits are stored.
- R3: IIR reads 0x04 when LSR bit 0 (data ready) and IER bit 0 are both set. Otherwise it reads 0x02 when the pending flag and IER bit 1 are both set. Otherwise it reads 0x01. irq is high exactly when IIR is not 0x01.
- R4: A data write (addr 0, LCR bit 7 clear) clears LSR bits 5 and 6 and the pending flag. Outside loopback, it pulses tx_strobe for one cycle with the byte on tx_data, both visible after the write edge. A tx_done pulse sets LSR bits 5 and 6 and the pending flag at its sampling edge.
- R5: Writing IER while LSR bit 5 is set raises the pending flag. A read of IIR that returns 0x02 clears the pending flag.
- R6: Reading the receive buffer (addr 0, LCR bit 7 clear) clears LSR bit 0 and LSR bit 4.
- R7: When LSR bit 0 is clear, rx_valid loads rx_data into the receive buffer and sets LSR bit 0. Under the same condition, rx_break loads 0x00 and sets LSR bits 4 and 0. Both inputs are ignored while LSR bit 0 is set.
- R8: In loopback (MCR bit 4), a data write loads the byte into the receive buffer and sets LSR bit 0 without any tx_strobe. LSR bits 5 and 6 return one cycle later. Line receive inputs are ignored in this mode.
- R9: In loopback, MSR reads bit7=MCR[3], bit6=MCR[2], bit5=MCR[0], bit4=MCR[1], and bits 3:0 read zero. Outside loopback, MSR reads the stored status 0xB0.
- R10: char_bits equals LCR[1:0]+5 and break_out equals LCR bit 6.
- R11: Address 7 reads back the last byte written to it. Writes to addresses 2, 5 and 6 change no readable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects at the clock edge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| irq | output | 1 | Level interrupt |
| tx_data | output | 8 | Byte handed to the line |
| tx_strobe | output | 1 | One-cycle send pulse |
| tx_done | input | 1 | Line finished the byte |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_break | input | 1 | Break event strobe |
| divisor | output | 16 | Baud divisor |
| char_bits | output | 4 | Character length in bits |
| break_out | output | 1 | Break level to the line |

## Verification
Read data is combinational, so the bench samples bus_rdata one nanosecond after it applies a read at the falling edge. The read side effects then take place at the following rising edge. Every write, tx_done, rx_valid and rx_break takes effect at the next rising edge, and the bench checks the result at the falling edge right after it. tx_strobe is checked at that same falling edge and again one cycle later to confirm it is a single pulse. The loopback completion appears one further cycle after the write, so LSR is read both before and after that extra edge.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_IER  = 3'd1;
    localparam logic [2:0] A_IIR  = 3'd2;
    localparam logic [2:0] A_LCR  = 3'd3;
    localparam logic [2:0] A_MCR  = 3'd4;
    localparam logic [2:0] A_LSR  = 3'd5;
    localparam logic [2:0] A_MSR  = 3'd6;
    localparam logic [2:0] A_SCR  = 3'd7;

    localparam logic [7:0] IIR_NONE = 8'h01;
    localparam logic [7:0] IIR_TXE  = 8'h02;
    localparam logic [7:0] IIR_RXD  = 8'h04;
    localparam logic [7:0] MSR_IDLE = 8'hB0;

    typedef enum logic [1:0] {
        TX_EMPTY,
        TX_WAIT_LINE,
        TX_LOOPBACK
    } tx_state_e;
endpackage

// File: rtl/uart_rf_txctl.sv
module uart_rf_txctl
    import uart_rf_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              thr_wr,
    input  logic              loop_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ier_wr,
    input  logic              iir_txe_rd,
    input  logic              tx_done,
    output logic              tx_strobe,
    output logic [DATA_W-1:0] tx_data,
    output logic              thre,
    output logic              thr_pend
);
    tx_state_e state_q, state_d;
    logic      finish;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        finish  = 1'b0;
        unique case (state_q)
            TX_EMPTY: begin
                if (thr_wr) state_d = loop_en ? TX_LOOPBACK : TX_WAIT_LINE;
            end
            TX_WAIT_LINE: begin
                if (thr_wr)       state_d = loop_en ? TX_LOOPBACK : TX_WAIT_LINE;
                else if (tx_done) begin
                    state_d = TX_EMPTY;
                    finish  = 1'b1;
                end
            end
            TX_LOOPBACK: begin
                if (thr_wr) state_d = loop_en ? TX_LOOPBACK : TX_WAIT_LINE;
                else begin
                    state_d = TX_EMPTY;
                    finish  = 1'b1;
                end
            end
            default: state_d = TX_EMPTY;
        endcase
    end

    assign thre = (state_q == TX_EMPTY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_strobe <= 1'b0;
            tx_data   <= '0;
            thr_pend  <= 1'b0;
        end else begin
            tx_strobe <= thr_wr && !loop_en;
            if (thr_wr && !loop_en) tx_data <= wdata;
            if (thr_wr)                 thr_pend <= 1'b0;
            else if (finish)            thr_pend <= 1'b1;
            else if (ier_wr && thre)    thr_pend <= 1'b1;
            else if (iir_txe_rd)        thr_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rf_rxbuf.sv
module uart_rf_rxbuf #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loop_en,
    input  logic              lb_valid,
    input  logic [DATA_W-1:0] lb_data,
    input  logic              rx_valid,
    input  logic              rx_break,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rbr_rd,
    output logic [DATA_W-1:0] rbr,
    output logic              dr,
    output logic              bi
);
    logic line_ok;
    assign line_ok = !loop_en && !dr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbr <= '0;
            dr  <= 1'b0;
            bi  <= 1'b0;
        end else if (lb_valid) begin
            rbr <= lb_data;
            dr  <= 1'b1;
            bi  <= 1'b0;
        end else if (line_ok && rx_break) begin
            rbr <= '0;
            dr  <= 1'b1;
            bi  <= 1'b1;
        end else if (line_ok && rx_valid) begin
            rbr <= rx_data;
            dr  <= 1'b1;
        end else if (rbr_rd) begin
            dr <= 1'b0;
            bi <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
    import uart_rf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int BASE_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_strobe,
    input  logic              tx_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_valid,
    input  logic              rx_break,
    output logic [2*DATA_W-1:0] divisor,
    output logic [3:0]        char_bits,
    output logic              break_out
);
    localparam int DIV_W = 2 * DATA_W;

    logic [DATA_W-1:0] lcr_q, scr_q, rbr;
    logic [3:0]        ier_q;
    logic [4:0]        mcr_q;
    logic [DIV_W-1:0]  div_q;
    logic              dlab, loop_en, thre, thr_pend, dr, bi;
    logic              thr_wr, ier_wr, rbr_rd, iir_txe_rd;
    logic [DATA_W-1:0] iir, lsr, msr;

    assign dlab    = lcr_q[7];
    assign loop_en = mcr_q[4];

    assign thr_wr     = bus_wr && bus_addr == A_DATA && !dlab;
    assign ier_wr     = bus_wr && bus_addr == A_IER  && !dlab;
    assign rbr_rd     = bus_rd && bus_addr == A_DATA && !dlab;
    assign iir_txe_rd = bus_rd && bus_addr == A_IIR  && iir[2:0] == IIR_TXE[2:0];

    uart_rf_txctl #(.DATA_W(DATA_W)) txctl_i (
        .clk(clk), .rst_n(rst_n), .thr_wr(thr_wr), .loop_en(loop_en),
        .wdata(bus_wdata), .ier_wr(ier_wr), .iir_txe_rd(iir_txe_rd),
        .tx_done(tx_done), .tx_strobe(tx_strobe), .tx_data(tx_data),
        .thre(thre), .thr_pend(thr_pend)
    );

    uart_rf_rxbuf #(.DATA_W(DATA_W)) rxbuf_i (
        .clk(clk), .rst_n(rst_n), .loop_en(loop_en),
        .lb_valid(thr_wr && loop_en), .lb_data(bus_wdata),
        .rx_valid(rx_valid), .rx_break(rx_break), .rx_data(rx_data),
        .rbr_rd(rbr_rd), .rbr(rbr), .dr(dr), .bi(bi)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lcr_q <= '0;
            scr_q <= '0;
            ier_q <= '0;
            mcr_q <= '0;
            div_q <= '0;
        end else if (bus_wr) begin
            unique case (bus_addr)
                A_DATA: if (dlab) div_q[DATA_W-1:0] <= bus_wdata;
                A_IER: begin
                    if (dlab) div_q[DIV_W-1:DATA_W] <= bus_wdata;
                    else      ier_q <= bus_wdata[3:0];
                end
                A_LCR: lcr_q <= bus_wdata;
                A_MCR: mcr_q <= bus_wdata[4:0];
                A_SCR: scr_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        if (dr && ier_q[0])            iir = IIR_RXD;
        else if (thr_pend && ier_q[1]) iir = IIR_TXE;
        else                           iir = IIR_NONE;
    end

    assign irq = (iir != IIR_NONE);
    assign lsr = {1'b0, thre, thre, bi, 3'b000, dr};
    assign msr = loop_en ? {mcr_q[3], mcr_q[2], mcr_q[0], mcr_q[1], 4'b0000} : MSR_IDLE;

    always_comb begin
        unique case (bus_addr)
            A_DATA:  bus_rdata = dlab ? div_q[DATA_W-1:0] : rbr;
            A_IER:   bus_rdata = dlab ? div_q[DIV_W-1:DATA_W] : {4'b0000, ier_q};
            A_IIR:   bus_rdata = iir;
            A_LCR:   bus_rdata = lcr_q;
            A_MCR:   bus_rdata = {3'b000, mcr_q};
            A_LSR:   bus_rdata = lsr;
            A_MSR:   bus_rdata = msr;
            default: bus_rdata = scr_q;
        endcase
    end

    assign divisor   = div_q;
    assign char_bits = 4'(lcr_q[1:0]) + 4'(BASE_BITS);
    assign break_out = lcr_q[6];
endmodule

// File: rtl/uart_rf_chk.sv
module uart_rf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       irq,
    input logic       tx_strobe,
    input logic       rx_valid,
    input logic       dlab,
    input logic       loop_en,
    input logic       dr,
    input logic       thre,
    input logic [3:0] ier_q,
    input logic [7:0] rbr
);
    assert_rx_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dr && ier_q[0]) |-> irq);

    assert_thr_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && !dlab) |=> !thre);

    assert_strobe_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe |-> $past(bus_wr && bus_addr == 3'd0 && !dlab && !loop_en));

    assert_rbr_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd0 && !dlab && dr) |=> !dr);

    assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dr && rx_valid && !bus_wr && !(bus_rd && bus_addr == 3'd0 && !dlab)) |=> $stable(rbr));
endmodule

bind uart_regfile uart_rf_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .irq(irq), .tx_strobe(tx_strobe), .rx_valid(rx_valid),
    .dlab(dlab), .loop_en(loop_en), .dr(dr), .thre(thre), .ier_q(ier_q), .rbr(rbr)
);

// File: tb/uart_regfile_tb_top.sv
`timescale 1ns/1ps
module uart_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq, tx_strobe, break_out;
    logic [7:0]  tx_data;
    logic        tx_done = 1'b0, rx_valid = 1'b0, rx_break = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [15:0] divisor;
    logic [3:0]  char_bits;
    int errs = 0, checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    uart_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .tx_data(tx_data), .tx_strobe(tx_strobe), .tx_done(tx_done),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_break(rx_break),
        .divisor(divisor), .char_bits(char_bits), .break_out(break_out)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        // R1 reset values
        rd_chk("R1 IIR", 2, 8'h01);
        rd_chk("R1 LSR", 5, 8'h60);
        rd_chk("R1 MSR", 6, 8'hB0);
        rd_chk("R1 RBR", 0, 0);
        rd_chk("R1 IER", 1, 0);
        rd_chk("R1 LCR", 3, 0);
        rd_chk("R1 MCR", 4, 0);
        rd_chk("R1 SCR", 7, 0);
        chk("R1 irq", irq, 0);

        // R2 divisor sweep
        wr(3, 8'h80);
        for (int i = 0; i < 16; i++) begin
            logic [15:0] dv;
            dv = 16'(i * 4369) ^ 16'h5A3C;
            wr(0, dv[7:0]);
            wr(1, dv[15:8]);
            rd_chk("R2 DLL", 0, dv[7:0]);
            rd_chk("R2 DLM", 1, dv[15:8]);
            chk("R2 divisor out", divisor, dv);
        end
        wr(3, 8'h00);
        rd_chk("R2 IER behind latch", 1, 0);
        wr(1, 8'hF0);
        rd_chk("R2 IER low nibble", 1, 8'h00);
        chk("R2 divisor kept", divisor, 16'(15 * 4369) ^ 16'h5A3C);

        // R10 line control sweep
        for (int l = 0; l < 8; l++) begin
            wr(3, 8'((l & 3) | ((l >> 2) << 6)));
            chk("R10 char_bits", char_bits, (l & 3) + 5);
            chk("R10 break_out", break_out, l >> 2);
        end
        wr(3, 8'h00);

        // R11 scratch sweep and read-only writes
        for (int s = 0; s < 256; s++) begin
            wr(7, 8'(s));
            rd_chk("R11 scratch", 7, s);
        end
        do_reset();
        wr(2, 8'hFF); wr(5, 8'h00); wr(6, 8'h00);
        rd_chk("R11 IIR untouched", 2, 8'h01);
        rd_chk("R11 LSR untouched", 5, 8'h60);
        rd_chk("R11 MSR untouched", 6, 8'hB0);
        chk("R11 irq untouched", irq, 0);

        // R5 pending raised by IER write, cleared by IIR read
        wr(1, 8'h02);
        chk("R5 irq raised", irq, 1);
        rd_chk("R5 IIR txe", 2, 8'h02);
        rd_chk("R5 IIR cleared", 2, 8'h01);
        chk("R5 irq dropped", irq, 0);

        // R4 transmit handshake
        wr(0, 8'hA7);
        chk("R4 strobe", tx_strobe, 1);
        chk("R4 tx_data", tx_data, 8'hA7);
        rd_chk("R4 LSR busy", 5, 8'h00);
        chk("R4 strobe single", tx_strobe, 0);
        chk("R4 no irq while busy", irq, 0);
        tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
        chk("R4 irq after done", irq, 1);
        rd_chk("R4 LSR done", 5, 8'h60);
        rd_chk("R4 IIR after done", 2, 8'h02);
        wr(1, 8'h00);

        // R7 receive and hold, R6 read clears
        rx_data = 8'h3C; rx_valid = 1'b1; @(negedge clk); rx_valid = 1'b0;
        rd_chk("R7 LSR dr", 5, 8'h61);
        rx_data = 8'hC3; rx_valid = 1'b1; @(negedge clk); rx_valid = 1'b0;
        rx_break = 1'b1; @(negedge clk); rx_break = 1'b0;
        rd_chk("R7 LSR no break while dr", 5, 8'h61);
        rd_chk("R7 first byte kept", 0, 8'h3C);
        rd_chk("R6 dr cleared", 5, 8'h60);
        rx_break = 1'b1; @(negedge clk); rx_break = 1'b0;
        rd_chk("R7 break LSR", 5, 8'h71);
        rd_chk("R7 break byte", 0, 8'h00);
        rd_chk("R6 bi and dr cleared", 5, 8'h60);

        // R8 loopback transmit
        wr(4, 8'h10);
        wr(0, 8'h5E);
        chk("R8 no strobe", tx_strobe, 0);
        rd_chk("R8 LSR mid", 5, 8'h01);
        rd_chk("R8 LSR after", 5, 8'h61);
        rx_data = 8'h11; rx_valid = 1'b1;
        rd_chk("R8 looped byte", 0, 8'h5E);
        rx_valid = 1'b0;
        rd_chk("R8 line ignored", 5, 8'h60);

        // R9 loopback status mapping sweep
        for (int m = 0; m < 16; m++) begin
            wr(4, 8'(8'h10 | m));
            rd_chk("R9 MSR loop", 6, ((m >> 3) & 1) << 7 | ((m >> 2) & 1) << 6
                                   | (m & 1) << 5 | ((m >> 1) & 1) << 4);
        end
        wr(4, 8'h0F);
        rd_chk("R9 MSR normal", 6, 8'hB0);

        // R3 priority sweep
        for (int e = 0; e < 4; e++) begin
            for (int d = 0; d < 2; d++) begin
                int exp;
                do_reset();
                wr(4, 8'h10);
                wr(1, 8'(e));
                if (d == 1) begin
                    wr(0, 8'h99);
                    @(negedge clk);
                end
                exp = ((d == 1) && (e & 1)) ? 8'h04 : ((e & 2) ? 8'h02 : 8'h01);
                chk("R3 irq level", irq, exp != 1);
                rd_chk("R3 IIR code", 2, exp);
            end
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(100000 * 5);
        if (!finished) begin
            errs++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule